// File: doc/BRIEF.md
# Memory Dependence Wakeup Tracker

This block sits beside the issue logic of an out-of-order core and tracks in-flight memory operations (loads, stores and memory barriers), each tagged by a sequence number and a thread id. When a normal load or store is inserted, the block picks the older operation it must wait for. An active barrier takes precedence. If no barrier applies, an external dependence predictor is asked, through a combinational port driven with the instruction's PC. The new entry is then linked to that producer and held until the producer completes.

An entry is released for issue once both its register operands and its memory dependence are resolved. Released entries leave one per cycle on a valid/ready output backed by a small FIFO. The block also supports non-speculative entries, a replay queue for rescheduled operations, barrier retirement that respects newer barriers, and a per-thread squash of younger entries. Four event counters record inserted and conflicting loads and stores.

Top module: `memdep_tracker`

## Requirements
- R1: During and directly after a synchronous active-low reset, `rel_valid` is low and all four counters read zero.
- R2: An insert-barrier command (`cmd_op`=2) with `cmd_kind`=2 (full barrier) holds back every later load (`cmd_kind`=0) and store (`cmd_kind`=1). With `cmd_kind`=3 (write barrier) it holds back only later stores.
- R3: An insert (`cmd_op`=0) takes its producer from the applicable barrier's sequence number if one is active, otherwise from `pred_seq`, which answers `pred_pc`=`cmd_pc`. A producer of zero, or one not present in the table, means no dependence.
- R4: An entry without dependence is released once its registers are ready, either at insert (`cmd_regs_ready`) or on a registers-ready command (`cmd_op`=3). A dependent entry is not released before its producer completes.
- R5: Completing a store or barrier (`cmd_op`=7 with its sequence number) wakes its live dependents. Register-ready ones are released in table-slot order. The others become memory-ready and are released on their registers-ready command.
- R6: Completing a barrier lifts a barrier flag only if that flag's recorded sequence number equals the completed one, so a newer barrier stays in force.
- R7: A non-speculative insert (`cmd_op`=1) has no dependence check and is released only by a non-speculative-ready command (`cmd_op`=4), never by a registers-ready command.
- R8: A reschedule command (`cmd_op`=5) queues an entry. A replay command (`cmd_op`=6) releases every queued entry in queue order.
- R9: A squash (`cmd_op`=8) removes every entry of `cmd_tid` whose sequence number exceeds `cmd_seq`, including queued replays and waiting dependents. Removed entries are never released, and other threads are untouched.
- R10: Releases appear on `rel_valid`/`rel_seq`/`rel_tid`, are held stable while `rel_ready` is low, and are buffered 8 deep with none lost or reordered under backpressure.
- R11: The counters count loads and stores inserted (normal or non-speculative) and normal inserts that found a dependence, split by load and store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (0..8) |
| cmd_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| cmd_seq | input | 16 | Sequence number the command refers to |
| cmd_tid | input | 1 | Thread id |
| cmd_pc | input | 32 | Instruction PC for inserts |
| cmd_regs_ready | input | 1 | Registers already ready at insert |
| pred_pc | output | 32 | PC presented to the dependence predictor |
| pred_seq | input | 16 | Predicted producer sequence number, 0 for none |
| rel_valid | output | 1 | Released entry available |
| rel_ready | input | 1 | Consumer accepts the released entry |
| rel_seq | output | 16 | Sequence number of the released entry |
| rel_tid | output | 1 | Thread of the released entry |
| cnt_ld_ins | output | 16 | Loads inserted |
| cnt_st_ins | output | 16 | Stores inserted |
| cnt_ld_conf | output | 16 | Loads inserted with a dependence |
| cnt_st_conf | output | 16 | Stores inserted with a dependence |

## Verification
The bench uses the default 16-entry table, 16-bit sequence numbers and 8-deep output FIFO. This is small enough to sweep every combination of operation kind, barrier type, predictor answer and register readiness from a fresh reset, with the expected producer and release derived arithmetically for each. The 8-deep FIFO lets a burst of ten releases overflow into the table's pending bits, which exercises the path where stalled releases are drained in order.

// File: rtl/memdep_pkg.sv
// Shared command and operation-kind codes for the memory dependence tracker.
package memdep_pkg;

    typedef enum logic [3:0] {
        OP_INSERT   = 4'd0,
        OP_INS_NS   = 4'd1,
        OP_INS_BAR  = 4'd2,
        OP_REGS_RDY = 4'd3,
        OP_NS_RDY   = 4'd4,
        OP_RESCHED  = 4'd5,
        OP_REPLAY   = 4'd6,
        OP_COMPLETE = 4'd7,
        OP_SQUASH   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_MEMBAR = 2'd2,
        K_WRBAR = 2'd3
    } kind_e;

endpackage

// File: rtl/memdep_pick.sv
// Lowest-index picker: returns the index of the lowest set request bit.
// Assumes N >= 2; idx is zero when no request is set.
module memdep_pick #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/memdep_fifo.sv
// Synchronous FIFO with a registered store and first-word-fall-through output.
// Assumes push is not raised when full and pop not when empty (ignored if so).
module memdep_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign dout    = mem[rd_ptr];

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Write storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/memdep_tracker.sv
// Memory dependence wakeup tracker. Holds in-flight loads, stores and
// barriers, links each insert to a producer (active barrier first, then the
// external predictor), and releases entries once register and memory
// readiness both hold. Assumes at most one command per cycle and unique
// in-flight sequence numbers; inserts into a full table are dropped.
module memdep_tracker
    import memdep_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int SEQ_W     = 16,
    parameter int PC_W      = 32,
    parameter int OUT_DEPTH = 8,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [1:0]       cmd_kind,
    input  logic [SEQ_W-1:0] cmd_seq,
    input  logic             cmd_tid,
    input  logic [PC_W-1:0]  cmd_pc,
    input  logic             cmd_regs_ready,
    output logic [PC_W-1:0]  pred_pc,
    input  logic [SEQ_W-1:0] pred_seq,
    output logic             rel_valid,
    input  logic             rel_ready,
    output logic [SEQ_W-1:0] rel_seq,
    output logic             rel_tid,
    output logic [CNT_W-1:0] cnt_ld_ins,
    output logic [CNT_W-1:0] cnt_st_ins,
    output logic [CNT_W-1:0] cnt_ld_conf,
    output logic [CNT_W-1:0] cnt_st_conf
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int RQ_CW = $clog2(ENTRIES + 1);
    localparam int OF_CW = $clog2(OUT_DEPTH + 1);
    localparam int REL_W = SEQ_W + 1;

    // Entry table
    logic [ENTRIES-1:0] e_valid, e_tid, e_nonspec, e_regs, e_mem, e_wait, e_pend, e_inrep;
    logic [SEQ_W-1:0]   e_seq  [ENTRIES];
    logic [IDX_W-1:0]   e_dep  [ENTRIES];
    kind_e              e_kind [ENTRIES];

    // Barrier state
    logic             ld_bar_q, st_bar_q;
    logic [SEQ_W-1:0] ld_sn_q, st_sn_q;

    // Replay drain
    logic [RQ_CW-1:0] drain_cnt;

    op_e   op;
    kind_e kind;
    assign op      = op_e'(cmd_op);
    assign kind    = kind_e'(cmd_kind);
    assign pred_pc = cmd_pc;

    // Producer selection: barrier first, predictor otherwise.
    logic             is_ld, is_st;
    logic [SEQ_W-1:0] prod;
    assign is_ld = (kind == K_LOAD);
    assign is_st = (kind == K_STORE);
    assign prod  = (is_ld && ld_bar_q) ? ld_sn_q :
                   (is_st && st_bar_q) ? st_sn_q : pred_seq;

    logic [ENTRIES-1:0] prod_m, hit_m;
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_match
            assign prod_m[g] = e_valid[g] && (e_seq[g] == prod);
            assign hit_m[g]  = e_valid[g] && (e_seq[g] == cmd_seq);
        end
    endgenerate

    logic [IDX_W-1:0] prod_idx, hit_idx, free_idx, pend_idx;
    logic             prod_any, hit_any, free_any, pend_any;

    memdep_pick #(.N(ENTRIES)) u_pick_prod (.req(prod_m),   .idx(prod_idx), .any(prod_any));
    memdep_pick #(.N(ENTRIES)) u_pick_hit  (.req(hit_m),    .idx(hit_idx),  .any(hit_any));
    memdep_pick #(.N(ENTRIES)) u_pick_free (.req(~e_valid), .idx(free_idx), .any(free_any));
    memdep_pick #(.N(ENTRIES)) u_pick_pend (.req(e_pend),   .idx(pend_idx), .any(pend_any));

    logic has_dep;
    assign has_dep = (prod != '0) && prod_any;

    // Replay queue of table indices
    logic             rq_push, rq_pop, rq_empty, rq_full;
    logic [IDX_W-1:0] rq_head;
    logic [RQ_CW-1:0] rq_count;

    // Output FIFO of {tid, seq}
    logic             of_push, of_empty, of_full;
    logic [REL_W-1:0] of_din, of_dout;
    logic [OF_CW-1:0] of_count;

    // Release arbitration: replay drain first, then lowest pending slot.
    logic drain_go, drain_rel, pend_go;
    assign drain_go  = (drain_cnt != '0) && !rq_empty && !of_full;
    assign drain_rel = drain_go && e_valid[rq_head] && e_inrep[rq_head];
    assign pend_go   = !drain_go && pend_any && !of_full;
    assign of_push   = drain_rel || pend_go;
    assign of_din    = drain_go ? {e_tid[rq_head], e_seq[rq_head]}
                                : {e_tid[pend_idx], e_seq[pend_idx]};
    assign rq_pop    = drain_go;
    assign rq_push   = cmd_valid && (op == OP_RESCHED) && hit_any && !e_inrep[hit_idx];

    memdep_fifo #(.WIDTH(IDX_W), .DEPTH(ENTRIES)) u_replay_q (
        .clk(clk), .rst_n(rst_n), .push(rq_push), .din(hit_idx), .pop(rq_pop),
        .dout(rq_head), .empty(rq_empty), .full(rq_full), .count(rq_count)
    );

    memdep_fifo #(.WIDTH(REL_W), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n), .push(of_push), .din(of_din), .pop(rel_ready),
        .dout(of_dout), .empty(of_empty), .full(of_full), .count(of_count)
    );

    assign rel_valid = !of_empty;
    assign rel_seq   = of_dout[SEQ_W-1:0];
    assign rel_tid   = of_dout[SEQ_W];

    // Count down the replay snapshot; a replay command reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drain_cnt <= '0;
        else if (cmd_valid && op == OP_REPLAY)
            drain_cnt <= rq_count - RQ_CW'(drain_go);
        else if (drain_go)
            drain_cnt <= drain_cnt - 1'b1;
    end

    // Table, barrier and counter updates for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= '0; e_pend <= '0; e_inrep <= '0; e_wait <= '0;
            ld_bar_q <= 1'b0; st_bar_q <= 1'b0;
            ld_sn_q <= '0; st_sn_q <= '0;
            cnt_ld_ins <= '0; cnt_st_ins <= '0; cnt_ld_conf <= '0; cnt_st_conf <= '0;
        end else begin
            if (pend_go)   e_pend[pend_idx] <= 1'b0;
            if (drain_rel) e_inrep[rq_head] <= 1'b0;
            if (cmd_valid) begin
                case (op)
                    OP_INSERT, OP_INS_NS: if (free_any && (is_ld || is_st)) begin
                        e_valid[free_idx]   <= 1'b1;
                        e_tid[free_idx]     <= cmd_tid;
                        e_seq[free_idx]     <= cmd_seq;
                        e_kind[free_idx]    <= kind;
                        e_regs[free_idx]    <= cmd_regs_ready;
                        e_inrep[free_idx]   <= 1'b0;
                        e_dep[free_idx]     <= prod_idx;
                        e_nonspec[free_idx] <= (op == OP_INS_NS);
                        if (op == OP_INSERT) begin
                            e_mem[free_idx]  <= !has_dep;
                            e_wait[free_idx] <= has_dep;
                            e_pend[free_idx] <= !has_dep && cmd_regs_ready;
                            if (has_dep && is_ld) cnt_ld_conf <= cnt_ld_conf + 1'b1;
                            if (has_dep && is_st) cnt_st_conf <= cnt_st_conf + 1'b1;
                        end else begin
                            e_mem[free_idx]  <= 1'b0;
                            e_wait[free_idx] <= 1'b0;
                            e_pend[free_idx] <= 1'b0;
                        end
                        if (is_ld) cnt_ld_ins <= cnt_ld_ins + 1'b1;
                        else       cnt_st_ins <= cnt_st_ins + 1'b1;
                    end
                    OP_INS_BAR: if (free_any && !is_ld && !is_st) begin
                        e_valid[free_idx]   <= 1'b1;
                        e_tid[free_idx]     <= cmd_tid;
                        e_seq[free_idx]     <= cmd_seq;
                        e_kind[free_idx]    <= kind;
                        e_regs[free_idx]    <= 1'b0;
                        e_mem[free_idx]     <= 1'b1;
                        e_wait[free_idx]    <= 1'b0;
                        e_pend[free_idx]    <= 1'b0;
                        e_inrep[free_idx]   <= 1'b0;
                        e_dep[free_idx]     <= '0;
                        e_nonspec[free_idx] <= 1'b1;
                        st_bar_q <= 1'b1;
                        st_sn_q  <= cmd_seq;
                        if (kind == K_MEMBAR) begin
                            ld_bar_q <= 1'b1;
                            ld_sn_q  <= cmd_seq;
                        end
                    end
                    OP_REGS_RDY: if (hit_any) begin
                        e_regs[hit_idx] <= 1'b1;
                        if (e_mem[hit_idx] && !e_wait[hit_idx] && !e_nonspec[hit_idx])
                            e_pend[hit_idx] <= 1'b1;
                    end
                    OP_NS_RDY: if (hit_any && e_nonspec[hit_idx]) e_pend[hit_idx] <= 1'b1;
                    OP_RESCHED: if (rq_push) e_inrep[hit_idx] <= 1'b1;
                    OP_COMPLETE: if (hit_any) begin
                        e_valid[hit_idx] <= 1'b0;
                        e_pend[hit_idx]  <= 1'b0;
                        e_inrep[hit_idx] <= 1'b0;
                        if (e_kind[hit_idx] != K_LOAD) begin
                            for (int i = 0; i < ENTRIES; i++) begin
                                if (e_valid[i] && e_wait[i] && e_dep[i] == hit_idx) begin
                                    e_wait[i] <= 1'b0;
                                    e_mem[i]  <= 1'b1;
                                    if (e_regs[i]) e_pend[i] <= 1'b1;
                                end
                            end
                        end
                        if (e_kind[hit_idx] == K_MEMBAR && ld_sn_q == cmd_seq) ld_bar_q <= 1'b0;
                        if ((e_kind[hit_idx] == K_MEMBAR || e_kind[hit_idx] == K_WRBAR)
                            && st_sn_q == cmd_seq) st_bar_q <= 1'b0;
                    end
                    OP_SQUASH: begin
                        for (int i = 0; i < ENTRIES; i++) begin
                            if (e_valid[i] && e_tid[i] == cmd_tid && e_seq[i] > cmd_seq) begin
                                e_valid[i] <= 1'b0;
                                e_pend[i]  <= 1'b0;
                                e_inrep[i] <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/memdep_tracker_sva.sv
// Property checker for the memory dependence tracker, bound to the top.
// Assumes the same parameter values as the instance it is bound to.
module memdep_tracker_sva #(
    parameter int SEQ_W     = 16,
    parameter int CNT_W     = 16,
    parameter int OUT_DEPTH = 8,
    parameter int OF_CW     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic [SEQ_W-1:0] cmd_seq,
    input logic             rel_valid,
    input logic             rel_ready,
    input logic [SEQ_W-1:0] rel_seq,
    input logic             rel_tid,
    input logic [CNT_W-1:0] cnt_ld_ins,
    input logic [CNT_W-1:0] cnt_st_ins,
    input logic [CNT_W-1:0] cnt_ld_conf,
    input logic [CNT_W-1:0] cnt_st_conf,
    input logic             ld_bar_q,
    input logic             st_bar_q,
    input logic [SEQ_W-1:0] ld_sn_q,
    input logic [SEQ_W-1:0] st_sn_q,
    input logic             of_push,
    input logic             of_full,
    input logic [OF_CW-1:0] of_count,
    input logic             rq_push,
    input logic             rq_full
);
    import memdep_pkg::*;

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !rel_valid && cnt_ld_ins == '0 && cnt_st_ins == '0
                   && cnt_ld_conf == '0 && cnt_st_conf == '0);

    assert_ld_bar_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ld_bar_q) && $past(rst_n) |->
        $past(cmd_valid && cmd_op == OP_COMPLETE && cmd_seq == ld_sn_q));

    assert_st_bar_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_bar_q) && $past(rst_n) |->
        $past(cmd_valid && cmd_op == OP_COMPLETE && cmd_seq == st_sn_q));

    assert_replay_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_push && rq_full));

    assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && !rel_ready |=> rel_valid && $stable(rel_seq) && $stable(rel_tid));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(of_push && of_full) && of_count <= OF_CW'(OUT_DEPTH));

    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (cnt_ld_ins - $past(cnt_ld_ins)) <= CNT_W'(1) &&
        (cnt_st_ins - $past(cnt_st_ins)) <= CNT_W'(1) &&
        (cnt_ld_conf - $past(cnt_ld_conf)) <= CNT_W'(1) &&
        (cnt_st_conf - $past(cnt_st_conf)) <= CNT_W'(1));

endmodule

bind memdep_tracker memdep_tracker_sva #(
    .SEQ_W(SEQ_W), .CNT_W(CNT_W), .OUT_DEPTH(OUT_DEPTH), .OF_CW(OF_CW)
) u_sva (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_seq(cmd_seq),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_seq(rel_seq), .rel_tid(rel_tid),
    .cnt_ld_ins(cnt_ld_ins), .cnt_st_ins(cnt_st_ins),
    .cnt_ld_conf(cnt_ld_conf), .cnt_st_conf(cnt_st_conf),
    .ld_bar_q(ld_bar_q), .st_bar_q(st_bar_q), .ld_sn_q(ld_sn_q), .st_sn_q(st_sn_q),
    .of_push(of_push), .of_full(of_full), .of_count(of_count),
    .rq_push(rq_push), .rq_full(rq_full)
);

// File: tb/memdep_tracker_bench.sv
`timescale 1ns/1ps
module memdep_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_kind = '0;
    logic [15:0] cmd_seq = '0;
    logic        cmd_tid = 1'b0;
    logic [31:0] cmd_pc = '0;
    logic        cmd_regs_ready = 1'b0;
    logic [31:0] pred_pc;
    logic [15:0] pred_seq;
    logic        rel_valid;
    logic        rel_ready = 1'b0;
    logic [15:0] rel_seq;
    logic        rel_tid;
    logic [15:0] cnt_ld_ins, cnt_st_ins, cnt_ld_conf, cnt_st_conf;

    logic [15:0] map_seq = '0;
    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Predictor model: PC 0x100 maps to map_seq, every other PC to none.
    assign pred_seq = (pred_pc == 32'h100) ? map_seq : 16'd0;

    memdep_tracker u_memdep_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_kind(cmd_kind), .cmd_seq(cmd_seq), .cmd_tid(cmd_tid), .cmd_pc(cmd_pc),
        .cmd_regs_ready(cmd_regs_ready), .pred_pc(pred_pc), .pred_seq(pred_seq),
        .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_seq(rel_seq), .rel_tid(rel_tid),
        .cnt_ld_ins(cnt_ld_ins), .cnt_st_ins(cnt_st_ins),
        .cnt_ld_conf(cnt_ld_conf), .cnt_st_conf(cnt_st_conf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; rel_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cmd(input int op, input int kind, input int seq, input int tid,
                       input int pc, input bit rr);
        cmd_valid = 1'b1; cmd_op = 4'(op); cmd_kind = 2'(kind); cmd_seq = 16'(seq);
        cmd_tid = tid[0]; cmd_pc = pc; cmd_regs_ready = rr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic expect_rel(input int seq, input int tid, input string tag);
        int n = 0;
        while (!rel_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(rel_valid, {tag, " release missing"}, int'(rel_valid), 1);
        if (rel_valid) begin
            chk(rel_seq == 16'(seq), {tag, " seq"}, int'(rel_seq), seq);
            chk(rel_tid == tid[0], {tag, " tid"}, int'(rel_tid), tid);
            rel_ready = 1'b1;
            @(negedge clk);
            rel_ready = 1'b0;
        end
    endtask

    task automatic expect_none(input string tag);
        repeat (6) @(negedge clk);
        chk(!rel_valid, {tag, " unexpected release"}, int'(rel_seq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk(!rel_valid, "R1 rel_valid", int'(rel_valid), 0);
        chk(cnt_ld_ins == 0 && cnt_st_ins == 0, "R1 insert counters", int'(cnt_ld_ins + cnt_st_ins), 0);
        chk(cnt_ld_conf == 0 && cnt_st_conf == 0, "R1 conflict counters", int'(cnt_ld_conf + cnt_st_conf), 0);

        // Sweep: kind x barrier type x predictor answer x register readiness
        for (int k = 0; k < 2; k++) begin
            for (int b = 0; b < 3; b++) begin
                for (int pm = 0; pm < 2; pm++) begin
                    for (int rr = 0; rr < 2; rr++) begin
                        bit bar_ap, dep;
                        int prodn;
                        do_reset();
                        map_seq = pm ? 16'd5 : 16'd0;
                        cmd(0, 1, 5, 0, 32'h300, 1'b1);
                        expect_rel(5, 0, "R4 base store");
                        if (b != 0) cmd(2, (b == 1) ? 2 : 3, 10, 0, 0, 1'b0);
                        cmd(0, k, 30, 0, 32'h100, rr[0]);
                        // R2/R3: full barrier blocks both, write barrier stores only
                        bar_ap = (b == 1) || (b == 2 && k == 1);
                        dep = bar_ap || (pm == 1);
                        prodn = bar_ap ? 10 : 5;
                        if (!dep) begin
                            if (rr == 1) expect_rel(30, 0, "R3 independent ready");
                            else begin
                                expect_none("R4 waiting regs");
                                cmd(3, 0, 30, 0, 0, 1'b0);
                                expect_rel(30, 0, "R4 regs event");
                            end
                            if (b != 0) cmd(7, 0, 10, 0, 0, 1'b0);
                        end else begin
                            expect_none("R2 R3 dependent held");
                            if (prodn == 10) begin
                                cmd(7, 0, 5, 0, 0, 1'b0);
                                expect_none("R3 barrier beats predictor");
                            end else if (b != 0) begin
                                cmd(7, 0, 10, 0, 0, 1'b0);
                                expect_none("R2 unrelated barrier");
                            end
                            cmd(7, 0, prodn, 0, 0, 1'b0);
                            if (rr == 1) expect_rel(30, 0, "R5 wake ready");
                            else begin
                                expect_none("R5 wake not regs ready");
                                cmd(3, 0, 30, 0, 0, 1'b0);
                                expect_rel(30, 0, "R5 regs after wake");
                            end
                        end
                        // R11 counters
                        chk(cnt_ld_ins == 16'(k == 0), "R11 loads", int'(cnt_ld_ins), int'(k == 0));
                        chk(cnt_st_ins == 16'(1 + (k == 1)), "R11 stores", int'(cnt_st_ins), 1 + int'(k == 1));
                        chk(cnt_ld_conf == 16'(dep && k == 0), "R11 load conflicts", int'(cnt_ld_conf), int'(dep && k == 0));
                        chk(cnt_st_conf == 16'(dep && k == 1), "R11 store conflicts", int'(cnt_st_conf), int'(dep && k == 1));
                        // R6: barrier lifted after completion
                        cmd(0, 0, 40, 0, 32'h200, 1'b1);
                        expect_rel(40, 0, "R6 load after barrier done");
                        cmd(0, 1, 41, 0, 32'h200, 1'b1);
                        expect_rel(41, 0, "R6 store after barrier done");
                    end
                end
            end
        end

        // R6: an older barrier completing leaves the newer one in force
        do_reset();
        cmd(2, 2, 10, 0, 0, 1'b0);
        cmd(2, 2, 11, 0, 0, 1'b0);
        cmd(7, 0, 10, 0, 0, 1'b0);
        cmd(0, 0, 12, 0, 32'h200, 1'b1);
        expect_none("R6 newer barrier holds");
        cmd(7, 0, 11, 0, 0, 1'b0);
        expect_rel(12, 0, "R6 newer barrier done");

        // R7: non-speculative entry
        do_reset();
        cmd(1, 0, 50, 0, 32'h100, 1'b0);
        expect_none("R7 nonspec insert");
        cmd(3, 0, 50, 0, 0, 1'b0);
        expect_none("R7 regs event ignored");
        cmd(4, 0, 50, 0, 0, 1'b0);
        expect_rel(50, 0, "R7 nonspec ready");
        chk(cnt_ld_ins == 16'd1, "R11 nonspec load counted", int'(cnt_ld_ins), 1);

        // R8/R9: replay order with a squashed queued entry
        do_reset();
        map_seq = 16'd0;
        for (int s = 60; s < 63; s++) begin
            cmd(0, 0, s, 0, 32'h200, 1'b1);
            expect_rel(s, 0, "R4 replay setup");
        end
        cmd(5, 0, 61, 0, 0, 1'b0);
        cmd(5, 0, 60, 0, 0, 1'b0);
        cmd(5, 0, 62, 0, 0, 1'b0);
        expect_none("R8 reschedule alone");
        cmd(8, 0, 61, 0, 0, 1'b0);
        cmd(6, 0, 0, 0, 0, 1'b0);
        expect_rel(61, 0, "R8 replay first");
        expect_rel(60, 0, "R8 replay second");
        expect_none("R9 squashed replay dropped");

        // R5: several dependents, slot order, one not register-ready
        do_reset();
        map_seq = 16'd70;
        cmd(0, 1, 70, 0, 32'h300, 1'b1);
        expect_rel(70, 0, "R5 producer");
        cmd(0, 0, 71, 0, 32'h100, 1'b1);
        cmd(0, 0, 72, 0, 32'h100, 1'b1);
        cmd(0, 0, 73, 0, 32'h100, 1'b0);
        expect_none("R4 dependents held");
        cmd(7, 0, 70, 0, 0, 1'b0);
        expect_rel(71, 0, "R5 first dependent");
        expect_rel(72, 0, "R5 second dependent");
        expect_none("R5 unready dependent");
        cmd(3, 0, 73, 0, 0, 1'b0);
        expect_rel(73, 0, "R5 late regs");

        // R9: squash one thread's younger dependent, keep the other thread
        do_reset();
        map_seq = 16'd80;
        cmd(0, 1, 80, 0, 32'h300, 1'b1);
        expect_rel(80, 0, "R9 producer");
        cmd(0, 0, 81, 0, 32'h100, 1'b1);
        cmd(0, 0, 82, 1, 32'h100, 1'b1);
        cmd(8, 0, 80, 0, 0, 1'b0);
        cmd(7, 0, 80, 0, 0, 1'b0);
        expect_rel(82, 1, "R9 other thread kept");
        expect_none("R9 squashed dependent");

        // R10: backpressure beyond the output FIFO depth
        do_reset();
        for (int s = 100; s < 110; s++) cmd(0, 0, s, 0, 32'h200, 1'b1);
        repeat (20) @(negedge clk);
        chk(rel_valid && rel_seq == 16'd100, "R10 held head", int'(rel_seq), 100);
        for (int s = 100; s < 110; s++) expect_rel(s, 0, "R10 drain order");
        expect_none("R10 drained");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule